// File: doc/BRIEF.md
# SD Command Transaction Sequencer

This block runs one SD/MMC command transaction from a single start strobe. On the strobe it latches the command configuration word, the 32-bit argument and the 16-bit watchdog limit. It then hands a 40-bit command frame to an abstract command PHY. Depending on the configuration it waits for a short or long response, checks the returned index and the PHY's CRC verdict, and may wait while the card holds its busy line. Bit serialisation and CRC7 generation belong to the PHY and are not part of this block.

Each transaction ends with exactly one completion event. A success event may carry a read or write data-phase launch pulse. An error event comes with one or more cause flags: timeout, CRC or index. The captured response is presented as four 32-bit words, least significant word first.

The states are IDLE, SEND, RESP, WBUSY and FIN. The transitions are as follows.
- IDLE to SEND on start.
- SEND to RESP when the frame is sent and a response is expected.
- SEND to WBUSY when the frame is sent, no response is expected and busy-wait is on.
- SEND to FIN when the frame is sent, no response is expected and busy-wait is off.
- RESP to FIN on an arriving response that has a check error, or that is clean with busy-wait off.
- RESP to WBUSY on a clean response with busy-wait on.
- WBUSY to FIN when the card is no longer busy.
- SEND, RESP or WBUSY to FIN when the watchdog expires.
- FIN to IDLE always.

Top module: `sdcmd_seq`

## Requirements
- R1: While the block is idle, a high `start_i` latches the configuration word, argument and timeout, and the block becomes busy in the next cycle. In SEND it raises `phy_req_o` with `phy_frame_o = {2'b01, cfg[13:8], arg}`. Later changes on these inputs have no effect until the next start.
- R2: The response type is `cfg[1:0]`: 0 means no response is awaited, 1 means short, and 2 or 3 mean long. `phy_resp_long_o` equals `cfg[1]` of the latched word.
- R3: A response accepted in RESP is stored in `resp_o` whatever its check result. For a short response, word 0 takes data bits 31:0 and words 1 to 3 are cleared. For a long response, bits 119:0 are stored and bits 127:120 are zero. With no response, or on a timeout, `resp_o` keeps its value. It reads zero after reset.
- R4: When `cfg[4]` is set, a response whose index differs from `cfg[13:8]` raises `evt_idx_o`.
- R5: When `cfg[3]` is set, a response with `phy_resp_crc_ok_i` low raises `evt_crc_o`.
- R6: When `cfg[2]` is set and no check error occurred, the block waits after the response (or after the send, for type 0) until `card_busy_i` is sampled low. When `cfg[2]` is clear, `card_busy_i` is ignored.
- R7: The watchdog counts `tick_i` cycles from the start. Once the count reaches a nonzero limit T, the next edge in SEND, RESP or WBUSY ends the transaction with `evt_tmo_o`. If a response arrives in that same cycle, the timeout wins and the response is discarded.
- R8: A timeout limit of zero disables the watchdog.
- R9: Any cause flag (timeout, CRC, index) comes with `evt_err_o`.
- R10: Each transaction produces exactly one one-cycle completion pulse, either `evt_done_o` or `evt_err_o`, in FIN. `busy_o` is low in the following cycle.
- R11: The data mode is `cfg[6:5]`: 1 means read and 2 means write. `rd_start_o` or `wr_start_o` pulses together with `evt_done_o` only. Modes 0 and 3 launch nothing.
- R12: A start that arrives while the block is busy is ignored. The watchdog count restarts from zero at every accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| cfg_i | input | 14 | Command configuration word |
| arg_i | input | 32 | Command argument |
| timeout_i | input | 16 | Watchdog limit in tick cycles, 0 = off |
| tick_i | input | 1 | SD clock cycle enable for the watchdog |
| phy_req_o | output | 1 | Frame transmit request |
| phy_frame_o | output | 40 | Start/direction bits, index, argument |
| phy_resp_long_o | output | 1 | Expect a 136-bit response |
| phy_sent_i | input | 1 | PHY finished sending the frame |
| phy_resp_vld_i | input | 1 | Response received |
| phy_resp_idx_i | input | 6 | Index field of the response |
| phy_resp_crc_ok_i | input | 1 | PHY CRC verdict on the response |
| phy_resp_data_i | input | 120 | Response content bits |
| card_busy_i | input | 1 | Card busy indication |
| busy_o | output | 1 | Transaction in progress |
| resp_o | output | 128 | Response words 0 to 3, word 0 lowest |
| evt_done_o | output | 1 | Success pulse |
| evt_err_o | output | 1 | Combined error pulse |
| evt_tmo_o | output | 1 | Timeout cause |
| evt_crc_o | output | 1 | CRC cause |
| evt_idx_o | output | 1 | Index cause |
| rd_start_o | output | 1 | Launch read data phase |
| wr_start_o | output | 1 | Launch write data phase |

## Verification
The watchdog expiring and a response arriving can fall on the same clock edge. The bench provokes this by sweeping the response delay across a fixed limit of six ticks, so that the arrival lands before, on and after the expiry edge. It expects a timeout only when the arrival edge is at or after edge T+1, and in that case it also expects `resp_o` to keep its old value. The busy release and the expiry are swept against each other in the same way.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int IDX_W      = 6;
    localparam int CFG_W      = 14;
    localparam int IDX_LSB    = 8;
    localparam int RSVD_BIT   = 7;
    localparam int DMODE_LSB  = 5;
    localparam int IDXCHK_BIT = 4;
    localparam int CRCCHK_BIT = 3;
    localparam int BUSY_BIT   = 2;
    localparam int RTYPE_LSB  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RESP,
        ST_WBUSY,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic tmo;
        logic crc;
        logic idx;
    } err_flags_t;
endpackage

// File: rtl/sdcmd_watchdog.sv
module sdcmd_watchdog #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (run_i && tick_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (lim_q != '0) && (cnt_q >= lim_q);
endmodule

// File: rtl/sdcmd_check.sv
module sdcmd_check #(
    parameter int IDX_W = 6
) (
    input  logic             idx_chk_i,
    input  logic             crc_chk_i,
    input  logic [IDX_W-1:0] want_idx_i,
    input  logic [IDX_W-1:0] got_idx_i,
    input  logic             crc_ok_i,
    output logic             idx_err_o,
    output logic             crc_err_o
);
    assign idx_err_o = idx_chk_i && (want_idx_i != got_idx_i);
    assign crc_err_o = crc_chk_i && !crc_ok_i;
endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store #(
    parameter int WORD_W    = 32,
    parameter int NWORDS    = 4,
    parameter int RESP_BITS = 120
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_i,
    input  logic                     long_i,
    input  logic [RESP_BITS-1:0]     data_i,
    output logic [NWORDS*WORD_W-1:0] resp_o
);
    localparam int RESP_W = NWORDS * WORD_W;

    logic [RESP_W-1:0] padded;
    assign padded = RESP_W'(data_i);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (cap_i) begin
                word_q <= (long_i || (w == 0)) ? padded[w*WORD_W +: WORD_W] : '0;
            end
        end
        assign resp_o[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int TMO_W     = 16,
    parameter int WORD_W    = 32,
    parameter int NWORDS    = 4,
    parameter int RESP_BITS = 120
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CFG_W-1:0]         cfg_i,
    input  logic [ARG_W-1:0]         arg_i,
    input  logic [TMO_W-1:0]         timeout_i,
    input  logic                     tick_i,
    output logic                     phy_req_o,
    output logic [2+IDX_W+ARG_W-1:0] phy_frame_o,
    output logic                     phy_resp_long_o,
    input  logic                     phy_sent_i,
    input  logic                     phy_resp_vld_i,
    input  logic [IDX_W-1:0]         phy_resp_idx_i,
    input  logic                     phy_resp_crc_ok_i,
    input  logic [RESP_BITS-1:0]     phy_resp_data_i,
    input  logic                     card_busy_i,
    output logic                     busy_o,
    output logic [NWORDS*WORD_W-1:0] resp_o,
    output logic                     evt_done_o,
    output logic                     evt_err_o,
    output logic                     evt_tmo_o,
    output logic                     evt_crc_o,
    output logic                     evt_idx_o,
    output logic                     rd_start_o,
    output logic                     wr_start_o
);
    localparam int RESP_W = NWORDS * WORD_W;

    seq_state_t       st_q, st_d;
    err_flags_t       err_q, err_d;
    logic [CFG_W-1:0] cfg_q;
    logic [ARG_W-1:0] arg_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       rtype_q, dmode_q;
    logic             accept, expired, running, cap_en;
    logic             idx_err, crc_err, busy_en, resp_none, fin, any_err;
    logic             cfg_unused;

    assign idx_q      = cfg_q[IDX_LSB +: IDX_W];
    assign rtype_q    = cfg_q[RTYPE_LSB +: 2];
    assign dmode_q    = cfg_q[DMODE_LSB +: 2];
    assign busy_en    = cfg_q[BUSY_BIT];
    assign resp_none  = (rtype_q == 2'd0);
    assign cfg_unused = cfg_q[RSVD_BIT];

    assign accept  = (st_q == ST_IDLE) && start_i;
    assign running = (st_q == ST_SEND) || (st_q == ST_RESP) || (st_q == ST_WBUSY);

    // Command parameters are frozen for the life of a transaction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            arg_q <= '0;
        end else if (accept) begin
            cfg_q <= cfg_i;
            arg_q <= arg_i;
        end
    end

    sdcmd_watchdog #(.TMO_W(TMO_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .run_i     (running),
        .tick_i    (tick_i),
        .limit_i   (timeout_i),
        .expired_o (expired)
    );

    sdcmd_check #(.IDX_W(IDX_W)) u_check (
        .idx_chk_i  (cfg_q[IDXCHK_BIT]),
        .crc_chk_i  (cfg_q[CRCCHK_BIT]),
        .want_idx_i (idx_q),
        .got_idx_i  (phy_resp_idx_i),
        .crc_ok_i   (phy_resp_crc_ok_i),
        .idx_err_o  (idx_err),
        .crc_err_o  (crc_err)
    );

    sdcmd_resp_store #(
        .WORD_W    (WORD_W),
        .NWORDS    (NWORDS),
        .RESP_BITS (RESP_BITS)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_en),
        .long_i (rtype_q[1]),
        .data_i (phy_resp_data_i),
        .resp_o (resp_o)
    );

    // State register and error flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            err_q <= '0;
        end else begin
            st_q  <= st_d;
            err_q <= accept ? '0 : err_d;
        end
    end

    // Next state: the watchdog outranks every other event.
    always_comb begin
        st_d   = st_q;
        err_d  = err_q;
        cap_en = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) st_d = ST_SEND;
            end
            ST_SEND: begin
                if (expired) begin
                    err_d.tmo = 1'b1;
                    st_d      = ST_FIN;
                end else if (phy_sent_i) begin
                    if (!resp_none) st_d = ST_RESP;
                    else if (busy_en) st_d = ST_WBUSY;
                    else st_d = ST_FIN;
                end
            end
            ST_RESP: begin
                if (expired) begin
                    err_d.tmo = 1'b1;
                    st_d      = ST_FIN;
                end else if (phy_resp_vld_i) begin
                    cap_en    = 1'b1;
                    err_d.idx = idx_err;
                    err_d.crc = crc_err;
                    if (idx_err || crc_err) st_d = ST_FIN;
                    else if (busy_en) st_d = ST_WBUSY;
                    else st_d = ST_FIN;
                end
            end
            ST_WBUSY: begin
                if (expired) begin
                    err_d.tmo = 1'b1;
                    st_d      = ST_FIN;
                end else if (!card_busy_i) begin
                    st_d = ST_FIN;
                end
            end
            ST_FIN: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from state and flags.
    always_comb begin
        fin             = (st_q == ST_FIN);
        any_err         = err_q.tmo || err_q.crc || err_q.idx;
        busy_o          = (st_q != ST_IDLE);
        phy_req_o       = (st_q == ST_SEND);
        phy_frame_o     = {2'b01, idx_q, arg_q};
        phy_resp_long_o = rtype_q[1];
        evt_done_o      = fin && !any_err;
        evt_err_o       = fin && any_err;
        evt_tmo_o       = fin && err_q.tmo;
        evt_crc_o       = fin && err_q.crc;
        evt_idx_o       = fin && err_q.idx;
        rd_start_o      = evt_done_o && (dmode_q == 2'd1);
        wr_start_o      = evt_done_o && (dmode_q == 2'd2);
    end
endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk #(
    parameter int RESP_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              phy_req_o,
    input logic [RESP_W-1:0] resp_o,
    input logic              evt_done_o,
    input logic              evt_err_o,
    input logic              evt_tmo_o,
    input logic              evt_crc_o,
    input logic              evt_idx_o,
    input logic              rd_start_o,
    input logic              wr_start_o
);
    AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req_o |-> busy_o); // R1
    AST_RESP_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(resp_o)); // R3
    AST_CAUSE_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tmo_o || evt_crc_o || evt_idx_o) |-> evt_err_o); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_done_o, evt_err_o})); // R10
    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done_o || evt_err_o) |=> !busy_o); // R10
    AST_DATA_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start_o || wr_start_o) |-> evt_done_o); // R11
    AST_DATA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start_o && wr_start_o)); // R11
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R12
endmodule

bind sdcmd_seq sdcmd_seq_chk #(.RESP_W(RESP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .phy_req_o  (phy_req_o),
    .resp_o     (resp_o),
    .evt_done_o (evt_done_o),
    .evt_err_o  (evt_err_o),
    .evt_tmo_o  (evt_tmo_o),
    .evt_crc_o  (evt_crc_o),
    .evt_idx_o  (evt_idx_o),
    .rd_start_o (rd_start_o),
    .wr_start_o (wr_start_o)
);

// File: tb/sdcmd_seq_tb.sv
module sdcmd_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [13:0]  cfg_i = '0;
    logic [31:0]  arg_i = '0;
    logic [15:0]  timeout_i = '0;
    logic         tick_i = 1'b1;
    logic         phy_req_o;
    logic [39:0]  phy_frame_o;
    logic         phy_resp_long_o;
    logic         phy_sent_i = 1'b0;
    logic         phy_resp_vld_i = 1'b0;
    logic [5:0]   phy_resp_idx_i = '0;
    logic         phy_resp_crc_ok_i = 1'b0;
    logic [119:0] phy_resp_data_i = '0;
    logic         card_busy_i = 1'b0;
    logic         busy_o;
    logic [127:0] resp_o;
    logic         evt_done_o, evt_err_o, evt_tmo_o, evt_crc_o, evt_idx_o;
    logic         rd_start_o, wr_start_o;

    int n_chk = 0;
    int n_fail = 0;
    int txn_id = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .arg_i(arg_i),
        .timeout_i(timeout_i), .tick_i(tick_i), .phy_req_o(phy_req_o),
        .phy_frame_o(phy_frame_o), .phy_resp_long_o(phy_resp_long_o),
        .phy_sent_i(phy_sent_i), .phy_resp_vld_i(phy_resp_vld_i),
        .phy_resp_idx_i(phy_resp_idx_i), .phy_resp_crc_ok_i(phy_resp_crc_ok_i),
        .phy_resp_data_i(phy_resp_data_i), .card_busy_i(card_busy_i), .busy_o(busy_o),
        .resp_o(resp_o), .evt_done_o(evt_done_o), .evt_err_o(evt_err_o),
        .evt_tmo_o(evt_tmo_o), .evt_crc_o(evt_crc_o), .evt_idx_o(evt_idx_o),
        .rd_start_o(rd_start_o), .wr_start_o(wr_start_o)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s txn=%0d actual=%0h expected=%0h", req, txn_id, act, exp);
        end
    endtask

    // One transaction with a PHY model; every expectation is derived from the requirements.
    task automatic txn(input logic [13:0] cfg, input logic [15:0] tmo, input int rdly,
                       input bit idx_ok, input bit crc_ok, input int busy_len, input bit poke);
        logic [31:0]  arg;
        logic [119:0] dat;
        logic [127:0] prev, exp_resp;
        int  tmo_edge, k, fin_n;
        bit  has_resp, e_tmo, e_crc, e_idx, e_err;
        bit  g_done, g_err, g_tmo, g_crc, g_idx, g_rd, g_wr;
        txn_id++;
        arg  = txn_id * 32'h9E37_79B1;
        dat  = {arg[23:0], arg ^ 32'h5A5A_A5A5, ~arg, arg + 32'h1234_5678};
        prev = resp_o;
        has_resp = (cfg[1:0] != 2'd0);
        tmo_edge = (tmo == 16'd0) ? 100000 : int'(tmo) + 1;
        e_tmo = 1'b0; e_crc = 1'b0; e_idx = 1'b0;
        if (has_resp) begin
            k = 2 + rdly;
            if (k >= tmo_edge) begin
                e_tmo = 1'b1; k = tmo_edge;
            end else begin
                e_idx = cfg[4] && !idx_ok;
                e_crc = cfg[3] && !crc_ok;
            end
        end else begin
            k = 1;
        end
        if (!e_tmo && !e_idx && !e_crc && cfg[2]) begin
            k = (k + 1 > busy_len + 1) ? k + 1 : busy_len + 1;
            if (k >= tmo_edge) begin
                e_tmo = 1'b1; k = tmo_edge;
            end
        end
        e_err = e_tmo || e_idx || e_crc;
        if (has_resp && !e_tmo)
            exp_resp = cfg[1] ? {8'h0, dat} : {96'h0, dat[31:0]};
        else
            exp_resp = prev;

        @(negedge clk);
        start_i = 1'b1; cfg_i = cfg; arg_i = arg; timeout_i = tmo;
        card_busy_i = (busy_len > 0);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1 busy after start", 128'(busy_o), 128'd1);
        chk(phy_req_o == 1'b1, "R1 request", 128'(phy_req_o), 128'd1);
        chk(phy_frame_o == {2'b01, cfg[13:8], arg}, "R1 frame", 128'(phy_frame_o),
            128'({2'b01, cfg[13:8], arg}));
        chk(phy_resp_long_o == cfg[1], "R2 long flag", 128'(phy_resp_long_o), 128'(cfg[1]));
        phy_sent_i = 1'b1;
        cfg_i = ~cfg; arg_i = ~arg; timeout_i = 16'd1;
        fin_n = -1;
        g_done = 0; g_err = 0; g_tmo = 0; g_crc = 0; g_idx = 0; g_rd = 0; g_wr = 0;
        for (int n = 1; n <= 90; n++) begin
            @(negedge clk);
            phy_sent_i = 1'b0; phy_resp_vld_i = 1'b0; start_i = 1'b0;
            card_busy_i = (n < busy_len);
            if (evt_done_o || evt_err_o) begin
                fin_n = n;
                g_done = evt_done_o; g_err = evt_err_o; g_tmo = evt_tmo_o;
                g_crc = evt_crc_o; g_idx = evt_idx_o; g_rd = rd_start_o; g_wr = wr_start_o;
                break;
            end
            if (has_resp && n == 1 + rdly) begin
                phy_resp_vld_i = 1'b1;
                phy_resp_idx_i = idx_ok ? cfg[13:8] : ~cfg[13:8];
                phy_resp_crc_ok_i = crc_ok;
                phy_resp_data_i = dat;
            end
            if (poke && n == 2) begin
                start_i = 1'b1; cfg_i = cfg ^ 14'h3FFF;
            end
        end
        chk(fin_n == k, "R6 finish cycle", 128'(fin_n), 128'(k));
        chk(g_tmo == e_tmo, "R7 timeout event", 128'(g_tmo), 128'(e_tmo));
        chk(g_idx == e_idx, "R4 index event", 128'(g_idx), 128'(e_idx));
        chk(g_crc == e_crc, "R5 crc event", 128'(g_crc), 128'(e_crc));
        chk(g_err == e_err, "R9 error event", 128'(g_err), 128'(e_err));
        chk(g_done == !e_err, "R10 done event", 128'(g_done), 128'(!e_err));
        chk(g_rd == (!e_err && cfg[6:5] == 2'd1), "R11 read launch", 128'(g_rd),
            128'(!e_err && cfg[6:5] == 2'd1));
        chk(g_wr == (!e_err && cfg[6:5] == 2'd2), "R11 write launch", 128'(g_wr),
            128'(!e_err && cfg[6:5] == 2'd2));
        @(negedge clk);
        card_busy_i = 1'b0; start_i = 1'b0;
        chk(!busy_o && !evt_done_o && !evt_err_o, "R10 idle after end",
            128'({busy_o, evt_done_o, evt_err_o}), 128'd0);
        chk(resp_o == exp_resp, "R3 response words", resp_o, exp_resp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !phy_req_o, "R1 reset idle", 128'({busy_o, phy_req_o}), 128'd0);
        chk(!evt_done_o && !evt_err_o, "R10 reset no event", 128'({evt_done_o, evt_err_o}), 128'd0);
        chk(resp_o == '0, "R3 reset response", resp_o, 128'd0);

        // Sweep every option combination with both check outcomes.
        for (int rt = 0; rt < 4; rt++)
            for (int ic = 0; ic < 2; ic++)
                for (int cc = 0; cc < 2; cc++)
                    for (int be = 0; be < 2; be++)
                        for (int dm = 0; dm < 4; dm++)
                            for (int iok = 0; iok < 2; iok++)
                                for (int cok = 0; cok < 2; cok++)
                                    txn({6'(rt * 13 + dm * 5 + ic * 3 + 1), 1'b0, 2'(dm),
                                         1'(ic), 1'(cc), 1'(be), 2'(rt)},
                                        16'd60, (iok + cok + rt) % 3, iok[0], cok[0],
                                        (be != 0) ? 7 : 3, 1'b0);

        // R7: response arrival swept across the expiry edge of a 6-tick limit.
        for (int d = 0; d < 9; d++)
            txn({6'd17, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1}, 16'd6, d, 1'b1, 1'b1, 0, 1'b0);
        // R7: busy release swept across the expiry edge.
        for (int b = 4; b < 14; b++)
            txn({6'd9, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0}, 16'd10, 0, 1'b1, 1'b1, b, 1'b0);
        // R8: zero limit never expires.
        txn({6'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2}, 16'd0, 40, 1'b1, 1'b1, 0, 1'b0);
        txn({6'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0}, 16'd0, 0, 1'b1, 1'b1, 60, 1'b0);
        // R12: back-to-back timed transactions need the count cleared at start.
        txn({6'd5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1}, 16'd8, 12, 1'b1, 1'b1, 0, 1'b0);
        txn({6'd5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1}, 16'd8, 5, 1'b1, 1'b1, 0, 1'b0);
        // R12: a start while busy changes nothing.
        txn({6'd21, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1}, 16'd30, 4, 1'b1, 1'b1, 0, 1'b1);
        txn({6'd22, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd2}, 16'd30, 4, 1'b1, 1'b1, 9, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule